// File: doc/BRIEF.md
# 8-bit Timer Counter with Selectable Count Source

This block is an 8-bit counter that only ever counts upward and is never cleared by its own hardware. What makes it advance is chosen by a 3-bit source-select field. The field can stop the counter, step it on every system clock, step it on one of four prescaled tick rates, or step it on a falling or rising edge of an external pin. The tick rates come from a free-running 10-bit divider.

When the count passes 0xFF it wraps to 0x00 and sets an overflow flag. The overflow flag ANDed with a mask bit forms the interrupt request. A small register port with a 2-bit address lets the CPU read and write the count, the source select, the flag and the mask. A write to the count takes priority over an increment in the same cycle. Software clears the flag by writing a one to it.

Top module: `timer8_clksel`

## Requirements
- R1: After a synchronous active-low reset, the count, the source select, the overflow flag and the mask all read 0, and `ovf_irq` is 0.
- R2: With source select 0 the count holds its value. The CPU can still write the count and read it back unchanged.
- R3: With source select 1 the count advances by one on every clock. From 0xFF it wraps to 0x00.
- R4: Source selects 2, 3, 4 and 5 advance the count once every 8, 64, 256 and 1024 clocks. The divider is 10 bits wide, starts at 0 at reset and runs freely. The count steps at the edge where the divider's low 3, 6, 8 or 10 bits are all ones.
- R5: Source select 6 counts falling edges of `ext_pin` and select 7 counts rising edges. The pin passes through two synchroniser stages. The count changes at the third clock edge that samples the new pin level.
- R6: A CPU write to the count loads `reg_wdata` and suppresses the increment in that cycle. A write of any value while the count is 0xFF does not set the overflow flag.
- R7: A wrap from 0xFF to 0x00 sets the overflow flag, which is bit 0 at address 2.
- R8: Writing 1 to bit 0 at address 2 clears the flag, and writing 0 leaves it unchanged. If a wrap happens in the same cycle as the clear, the flag stays set.
- R9: `ovf_irq` is the overflow flag ANDed with the mask, which is bit 0 at address 3.
- R10: The register map is: address 0 holds the count (8 bits), address 1 holds the source select in bits [2:0], address 2 holds the flag in bit 0, and address 3 holds the mask in bit 0. All other bits read 0. `reg_rdata` is combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external event pin |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| ovf_irq | output | 1 | Masked overflow interrupt request |

## Verification
The bench targets these corner cases:
- **Count write against increment.** A count write lands on a cycle that would otherwise increment. A design that let the increment win would read back one above the written value.
- **Write at 0xFF.** A count write lands while the count sits at 0xFF. A design that set the flag here would report an overflow that never happened.
- **Wrap against flag clear.** A flag clear coincides with a wrap. A design that let the clear win would lose that overflow.
- **Slow divider rates.** Every divider rate is compared cycle by cycle against a model of the free-running divider. An off-by-one tap or a divider that restarts on a source change would drift away from it.
- **Pin edges.** Pin activity includes single-cycle pulses. A design with the wrong edge polarity or the wrong synchroniser depth would step in the wrong cycle.

// File: rtl/tmr8_pkg.sv
// Package: shared types and constants for the 8-bit timer with source select.
// Assumes: a 3-bit select code and a 2-bit register address space.
package tmr8_pkg;

    typedef enum logic [2:0] {
        SRC_OFF      = 3'd0,
        SRC_SYS      = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_PIN_FALL = 3'd6,
        SRC_PIN_RISE = 3'd7
    } src_sel_e;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_SEL   = 2'd1;
    localparam logic [1:0] ADDR_FLAG  = 2'd2;
    localparam logic [1:0] ADDR_MASK  = 2'd3;

    localparam int NUM_TAPS = 4;

endpackage

// File: rtl/tick_prescaler.sv
// Module: tick_prescaler
// Free-running divider that produces one-cycle tick strobes for several
// power-of-two rates. Tap i strobes when the low TAP_BITS[i] bits of the
// divider are all ones.
// Assumes: every TAP_BITS entry lies between 1 and PRE_W.
module tick_prescaler
    import tmr8_pkg::*;
#(
    parameter int PRE_W = 10,
    parameter int TAP_BITS [NUM_TAPS] = '{3, 6, 8, 10}
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_TAPS-1:0] taps
);

    logic [PRE_W-1:0] div_q;

    // Advance the divider on every clock; it wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // One strobe per rate, taken from the all-ones state of the low bits.
    for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
        localparam int NB = TAP_BITS[gi];
        assign taps[gi] = &div_q[NB-1:0];
    end

    // R4: a divide-by-8 strobe never fires in two consecutive cycles.
    a_r4_tap_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        taps[0] |=> !taps[0]);

    // R4: a slower strobe implies every faster strobe fires in the same cycle.
    a_r4_tap_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        taps[NUM_TAPS-1] |-> (&taps));

endmodule

// File: rtl/pin_edge_detect.sv
// Module: pin_edge_detect
// Synchronises an asynchronous pin through SYNC_STAGES flops, then flags
// rising and falling transitions of the synchronised level for one cycle.
// Assumes: SYNC_STAGES >= 2. The pin reads low across reset.
module pin_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   lvl;

    assign lvl = sync_q[SYNC_STAGES-1];

    // Shift the raw pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    // Remember the previous synchronised level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= lvl;
    end

    // Derive one-cycle transition strobes.
    always_comb begin
        rise = lvl & ~last_q;
        fall = ~lvl & last_q;
    end

    // R5: two rising strobes cannot happen in consecutive cycles.
    a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R5: two falling strobes cannot happen in consecutive cycles.
    a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/count_core.sv
// Module: count_core
// Up-only counter with a load port. A load wins over a step in the same
// cycle. A wrap pulse is raised when a step moves the value from all ones
// to zero.
// Assumes: step and load are synchronous to clk.
module count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] value,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    assign value = cnt_q;

    // Flag a wrap only for a real step out of the top value.
    always_comb wrap = step && !load && (cnt_q == TOP);

    // Update the count: a load first, otherwise a step.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    // R6: a load always lands as written, whatever the step input did.
    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (value == $past(load_val)));

    // R3: a step out of the top value lands on zero.
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (value == '0));

    // R2: with neither step nor load the value holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(value));

endmodule

// File: rtl/timer8_clksel.sv
// Module: timer8_clksel (top)
// 8-bit timer with a selectable count source, an overflow flag, an
// interrupt mask and a 2-bit addressed register port.
// Assumes: register accesses are single-cycle strobes. ext_pin may be
// asynchronous.
module timer8_clksel
    import tmr8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             ovf_irq
);

    localparam int SEL_W = $bits(src_sel_e);

    src_sel_e            sel_q;
    logic                flag_q;
    logic                mask_q;
    logic [NUM_TAPS-1:0] taps;
    logic                pin_rise;
    logic                pin_fall;
    logic                step;
    logic                wrap;
    logic [CNT_W-1:0]    count;
    logic                wr_count;
    logic                wr_sel;
    logic                wr_flag;
    logic                wr_mask;
    logic                flag_clr;

    tick_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps)
    );

    pin_edge_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    count_core #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (wr_count),
        .load_val (reg_wdata),
        .value    (count),
        .wrap     (wrap)
    );

    // Decode the write strobes per register.
    always_comb begin
        wr_count = reg_wr && (reg_addr == ADDR_COUNT);
        wr_sel   = reg_wr && (reg_addr == ADDR_SEL);
        wr_flag  = reg_wr && (reg_addr == ADDR_FLAG);
        wr_mask  = reg_wr && (reg_addr == ADDR_MASK);
        flag_clr = wr_flag && reg_wdata[0];
    end

    // Choose the step source from the select code.
    always_comb begin
        case (sel_q)
            SRC_OFF:      step = 1'b0;
            SRC_SYS:      step = 1'b1;
            SRC_DIV8:     step = taps[0];
            SRC_DIV64:    step = taps[1];
            SRC_DIV256:   step = taps[2];
            SRC_DIV1024:  step = taps[3];
            SRC_PIN_FALL: step = pin_fall;
            SRC_PIN_RISE: step = pin_rise;
            default:      step = 1'b0;
        endcase
    end

    // Hold the source select written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= SRC_OFF;
        else if (wr_sel) sel_q <= src_sel_e'(reg_wdata[SEL_W-1:0]);
    end

    // Overflow flag: set on a wrap, cleared by writing one; the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (wrap)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Hold the interrupt mask written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= 1'b0;
        else if (wr_mask) mask_q <= reg_wdata[0];
    end

    // Return the addressed register with unused bits as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_COUNT: reg_rdata = count;
            ADDR_SEL:   reg_rdata[SEL_W-1:0] = sel_q;
            ADDR_FLAG:  reg_rdata[0] = flag_q;
            ADDR_MASK:  reg_rdata[0] = mask_q;
            default:    reg_rdata = '0;
        endcase
    end

    // Present the masked interrupt request.
    assign ovf_irq = flag_q & mask_q;

    // R7 and R8: a wrap always leaves the flag set, even with a clear pending.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);

    // R8: a clear with no wrap drops the flag.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !wrap) |=> !flag_q);

    // R2: with the source stopped and no count write the count holds.
    a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SRC_OFF && !wr_count) |=> $stable(count));

    // R9: no request while the mask is clear.
    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !ovf_irq);

endmodule

// File: tb/sim_timer8_clksel.sv
// Bench for timer8_clksel: a reference model built from the requirements,
// directed corner cases and seeded random traffic.
module sim_timer8_clksel;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ext_pin;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       ovf_irq;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    timer8_clksel u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_pin),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ovf_irq   (ovf_irq)
    );

    // Reference model state.
    logic [7:0] m_cnt;
    logic [2:0] m_sel;
    logic       m_flag;
    logic       m_mask;
    logic [9:0] m_div;
    logic       m_s1, m_s2, m_prev;

    function automatic logic m_step(input logic [2:0] s, input logic [9:0] d,
                                    input logic lv, input logic pv);
        case (s)
            3'd1:    return 1'b1;
            3'd2:    return d[2:0] == 3'h7;
            3'd3:    return d[5:0] == 6'h3f;
            3'd4:    return d[7:0] == 8'hff;
            3'd5:    return d == 10'h3ff;
            3'd6:    return !lv && pv;
            3'd7:    return lv && !pv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_cnt;
            2'd1:    return {5'd0, m_sel};
            2'd2:    return {7'd0, m_flag};
            default: return {7'd0, m_mask};
        endcase
    endfunction

    // Advance the model at each clock edge from the inputs driven at the negedge.
    always @(posedge clk) begin : model
        logic st, wr;
        if (!rst_n) begin
            m_cnt <= 0; m_sel <= 0; m_flag <= 0; m_mask <= 0;
            m_div <= 0; m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
        end else begin
            st = m_step(m_sel, m_div, m_s2, m_prev);
            wr = reg_wr && reg_addr == 2'd0;
            m_div <= m_div + 1'b1;
            m_s1 <= ext_pin; m_s2 <= m_s1; m_prev <= m_s2;
            if (wr)      m_cnt <= reg_wdata;
            else if (st) m_cnt <= m_cnt + 1'b1;
            if (st && !wr && m_cnt == 8'hff) m_flag <= 1'b1;
            else if (reg_wr && reg_addr == 2'd2 && reg_wdata[0]) m_flag <= 1'b0;
            if (reg_wr && reg_addr == 2'd1) m_sel <= reg_wdata[2:0];
            if (reg_wr && reg_addr == 2'd3) m_mask <= reg_wdata[0];
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the negedge, compare against the model, then wait.
    task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d,
                       input string tag);
        reg_wr = we; reg_addr = a; reg_wdata = d;
        #1;
        check(tag, reg_rdata, m_read(a));
        check(tag, {7'd0, ovf_irq}, {7'd0, m_flag & m_mask});
        @(negedge clk);
    endtask

    task automatic lit(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_wr = 0; reg_addr = a; reg_wdata = 0;
        #1;
        check(tag, reg_rdata, exp);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1234abcd;
        void'($urandom(seed));
        rst_n = 0; ext_pin = 0; reg_addr = 0; reg_wr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset values
        lit(2'd0, 8'h00, "R1 count");
        lit(2'd1, 8'h00, "R1 sel");
        lit(2'd2, 8'h00, "R1 flag");
        lit(2'd3, 8'h00, "R1 mask");
        check("R1 irq", {7'd0, ovf_irq}, 8'h00);

        // R2: stopped, write still works
        cyc(1, 2'd0, 8'h5a, "R2");
        repeat (20) cyc(0, 2'd0, 0, "R2");
        lit(2'd0, 8'h5a, "R2 hold");

        // R6: write beats increment; a write at 0xFF sets no flag
        cyc(1, 2'd1, 8'h01, "R3");
        cyc(1, 2'd0, 8'h33, "R6");
        lit(2'd0, 8'h33, "R6 load");
        cyc(1, 2'd0, 8'hfe, "R6");
        cyc(1, 2'd0, 8'hff, "R6");
        cyc(1, 2'd0, 8'h10, "R6");
        lit(2'd2, 8'h00, "R6 no flag");

        // R3, R7, R8: wrap sets flag; a clear in the wrap cycle loses
        cyc(1, 2'd0, 8'hfe, "R3");
        cyc(0, 2'd0, 0, "R3");
        cyc(1, 2'd2, 8'h01, "R8");
        lit(2'd2, 8'h01, "R8 set wins");
        cyc(1, 2'd2, 8'h00, "R8");
        lit(2'd2, 8'h01, "R8 zero ignored");

        // R9: mask gates the request
        cyc(1, 2'd3, 8'h01, "R9");
        check("R9 irq on", {7'd0, ovf_irq}, 8'h01);
        cyc(1, 2'd2, 8'h01, "R8");
        lit(2'd2, 8'h00, "R8 cleared");
        check("R9 irq off", {7'd0, ovf_irq}, 8'h00);

        // R10: upper select bits read zero
        cyc(1, 2'd1, 8'hf8, "R10");
        lit(2'd1, 8'h00, "R10 sel bits");

        // R4: each divider rate against the model
        for (int s = 2; s <= 5; s++) begin
            cyc(1, 2'd1, 8'(s), "R4");
            cyc(1, 2'd0, 8'hf0, "R4");
            repeat (2100) cyc(0, 2'd0, 0, "R4");
        end

        // R5: pin edges, including single-cycle pulses
        for (int s = 6; s <= 7; s++) begin
            cyc(1, 2'd1, 8'(s), "R5");
            for (int i = 0; i < 600; i++) begin
                if ($urandom_range(0, 3) == 0) ext_pin = ~ext_pin;
                cyc(0, 2'd0, 0, "R5");
            end
        end

        // R10: seeded random register traffic in every mode
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if ($urandom_range(0, 2) == 0) ext_pin = ~ext_pin;
            if (a == 2'd0 && $urandom_range(0, 1) == 0) d = 8'hff;
            cyc($urandom_range(0, 5) == 0, a, d, "R10");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule